// File: doc/BRIEF.md
# IDE DMA Sector Progress Tracker

This block follows a DMA transfer that a storage controller splits into chunks, and does the position arithmetic for it. A start strobe loads the initial position and names the device kind. For a disk, the position is a 512-byte sector number and a count of sectors still to move. For a packet (optical) device, it is a 2048-byte block address, a byte index inside that block, and a count of packet bytes still owed. Every chunk-completion event after the start reports an error flag for the chunk that just finished. It also gives the byte length of the next chunk, where zero means no further chunk follows.

On each event the engine first advances its position by the chunk that has just completed. After a start, that chunk counts as empty. The engine then tests whether the command is finished. If a next chunk is pending, it presents the 512-byte sector where that chunk begins. When the chunk list runs out or an error arrives, it pulses DMA-end and returns to idle. The block moves no data and builds no scatter-gather lists; a DMA engine and a media model around it use its outputs.

Top module: `ide_dma_tracker`

## Requirements
- R1: After reset `busy_o` is 0, `status_o` is 8'h00, and `next_valid_o`, `cmd_done_o`, `irq_o`, `err_o` and `dma_end_o` are all 0.
- R2: A `start_i` pulse while idle sets `busy_o` and clears `status_o` to 8'h00 in the next cycle. The first chunk event after it advances nothing, so its `next_sector_o` is the loaded start position.
- R3: In disk mode (`kind_i`=0), each event adds ceil(previous length / 512) to the sector number and subtracts the same amount from the 16-bit remaining sector count (wrapping).
- R4: After a disk-mode advance, if the remaining count equals zero, then one cycle after the event `cmd_done_o` and `irq_o` pulse and `status_o` becomes 8'h50 (ready bit 6, seek-complete bit 4). `status_o` holds between events.
- R5: In packet mode (`kind_i`=1), each event adds the previous length to the 11-bit byte index. The block address grows by the sum shifted right by 11, and the index keeps the sum's low 11 bits.
- R6: In packet mode the sector offered for the next chunk is block address × 4 plus index shifted right by 9.
- R7: In packet mode each event subtracts the previous length from the signed remaining byte count. A result of zero or less gives the same `cmd_done_o`/`irq_o` pulse and 8'h50 status as R4.
- R8: An event with length 0 and no error pulses `dma_end_o` one cycle later, leaves `next_valid_o` low and drops `busy_o`.
- R9: An event with `chunk_err_i`=1 advances nothing. One cycle later it pulses `err_o`, `irq_o` and `dma_end_o`, sets `status_o` to 8'h51 (error bit 0) and drops `busy_o`. `cmd_done_o` stays low.
- R10: Chunk events while idle, and `start_i` while busy, are ignored: no output pulses and no change to position or status.
- R11: An event with a nonzero length and no error pulses `next_valid_o` one cycle later, with `next_sector_o` holding the next chunk's start sector until the following launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a transfer (taken only while idle) |
| kind_i | input | 1 | Device kind: 0 disk, 1 packet |
| start_sector_i | input | SECT_W | Disk start sector |
| sector_count_i | input | CNT_W | Disk sectors to move |
| start_block_i | input | SECT_W-2 | Packet start block address |
| start_index_i | input | 11 | Packet byte index within the start block |
| packet_bytes_i | input | PKT_W | Packet bytes owed |
| chunk_valid_i | input | 1 | Chunk-completion event |
| chunk_len_i | input | LEN_W | Byte length of the next chunk, 0 for none |
| chunk_err_i | input | 1 | The completed chunk failed |
| busy_o | output | 1 | Transfer in progress |
| next_valid_o | output | 1 | Pulse: next chunk launched |
| next_sector_o | output | SECT_W | Start sector of the launched chunk |
| cmd_done_o | output | 1 | Pulse: command finished |
| status_o | output | 8 | Device status byte |
| irq_o | output | 1 | Pulse: interrupt request |
| err_o | output | 1 | Pulse: transfer aborted by error |
| dma_end_o | output | 1 | Pulse: DMA finished |

## Verification
The assertions check the handshake relations on every cycle. DMA-end leaves the engine idle, and an error always comes with DMA-end, an interrupt and the error status. Completion and error never coincide, and a completion always carries the interrupt and the 8'h50 status. An idle engine stays quiet without a start, and status holds between events. Only the bench scenarios can show the arithmetic: rounding up partial sectors, carrying the packet byte index into the block address, and the signed comparison on the packet byte count. The bench compares these sector values against its own model over directed and random chunk sequences.

// File: rtl/ide_trk_pkg.sv
`timescale 1ns/1ps
package ide_trk_pkg;

    localparam int IDX_W   = 11;   // byte index inside a 2048-byte packet block
    localparam int SEC_SH  = 9;    // log2 of a 512-byte sector
    localparam int STAT_W  = 8;

    localparam logic [STAT_W-1:0] STAT_BUSY = 8'h00;
    localparam logic [STAT_W-1:0] STAT_DONE = 8'h50;
    localparam logic [STAT_W-1:0] STAT_FAIL = 8'h51;

    typedef enum logic {
        KIND_DISK = 1'b0,
        KIND_PKT  = 1'b1
    } trk_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } trk_state_e;

    typedef struct packed {
        logic              upd;
        logic              cmd_done;
        logic              irq;
        logic              err;
        logic [STAT_W-1:0] status;
    } trk_resp_t;

endpackage

// File: rtl/ide_trk_disk_step.sv
`timescale 1ns/1ps
module ide_trk_disk_step #(
    parameter int LEN_W  = 16,
    parameter int SECT_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [SECT_W-1:0] sector,
    input  logic [CNT_W-1:0]  count,
    input  logic [LEN_W-1:0]  prev_len,
    output logic [SECT_W-1:0] sector_nx,
    output logic [CNT_W-1:0]  count_nx,
    output logic              done_nx
);
    import ide_trk_pkg::*;

    localparam int SUM_W = LEN_W + 1;
    localparam int N_W   = SUM_W - SEC_SH;

    logic [SUM_W-1:0] rounded;
    logic [N_W-1:0]   nsec;

    always_comb begin
        rounded   = SUM_W'(prev_len) + SUM_W'((1 << SEC_SH) - 1);
        nsec      = rounded[SUM_W-1:SEC_SH];
        sector_nx = sector + SECT_W'(nsec);
        count_nx  = count - CNT_W'(nsec);
        done_nx   = (count_nx == '0);
    end
endmodule

// File: rtl/ide_trk_pkt_step.sv
`timescale 1ns/1ps
module ide_trk_pkt_step #(
    parameter int LEN_W  = 16,
    parameter int SECT_W = 32,
    parameter int PKT_W  = 32
) (
    input  logic [SECT_W-3:0]                 block,
    input  logic [ide_trk_pkg::IDX_W-1:0]     index,
    input  logic [PKT_W-1:0]                  remain,
    input  logic [LEN_W-1:0]                  prev_len,
    output logic [SECT_W-3:0]                 block_nx,
    output logic [ide_trk_pkg::IDX_W-1:0]     index_nx,
    output logic [PKT_W-1:0]                  remain_nx,
    output logic                              done_nx,
    output logic [SECT_W-1:0]                 sector_nx
);
    import ide_trk_pkg::*;

    localparam int BLK_W = SECT_W - 2;
    localparam int SUM_W = LEN_W + 1;
    localparam int CAR_W = SUM_W - IDX_W;

    logic [SUM_W-1:0] sum;
    logic [CAR_W-1:0] carry;

    always_comb begin
        sum       = SUM_W'(index) + SUM_W'(prev_len);
        carry     = sum[SUM_W-1:IDX_W];
        block_nx  = block + BLK_W'(carry);
        index_nx  = sum[IDX_W-1:0];
        remain_nx = remain - PKT_W'(prev_len);
        // signed test: zero or negative means every owed byte has moved
        done_nx   = remain_nx[PKT_W-1] || (remain_nx == '0);
        sector_nx = {block_nx, 2'b00} + SECT_W'(index_nx[IDX_W-1:SEC_SH]);
    end
endmodule

// File: rtl/ide_trk_resp.sv
`timescale 1ns/1ps
module ide_trk_resp (
    input  logic                        event_ok,
    input  logic                        event_bad,
    input  logic                        finished,
    output ide_trk_pkg::trk_resp_t      resp
);
    import ide_trk_pkg::*;

    always_comb begin
        resp = '0;
        if (event_bad) begin
            resp.upd    = 1'b1;
            resp.err    = 1'b1;
            resp.irq    = 1'b1;
            resp.status = STAT_FAIL;
        end else if (event_ok && finished) begin
            resp.upd      = 1'b1;
            resp.cmd_done = 1'b1;
            resp.irq      = 1'b1;
            resp.status   = STAT_DONE;
        end
    end
endmodule

// File: rtl/ide_dma_tracker.sv
`timescale 1ns/1ps
module ide_dma_tracker #(
    parameter int LEN_W  = 16,
    parameter int SECT_W = 32,
    parameter int CNT_W  = 16,
    parameter int PKT_W  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              kind_i,
    input  logic [SECT_W-1:0] start_sector_i,
    input  logic [CNT_W-1:0]  sector_count_i,
    input  logic [SECT_W-3:0] start_block_i,
    input  logic [10:0]       start_index_i,
    input  logic [PKT_W-1:0]  packet_bytes_i,
    input  logic              chunk_valid_i,
    input  logic [LEN_W-1:0]  chunk_len_i,
    input  logic              chunk_err_i,
    output logic              busy_o,
    output logic              next_valid_o,
    output logic [SECT_W-1:0] next_sector_o,
    output logic              cmd_done_o,
    output logic [7:0]        status_o,
    output logic              irq_o,
    output logic              err_o,
    output logic              dma_end_o
);
    import ide_trk_pkg::*;

    localparam int BLK_W = SECT_W - 2;

    trk_state_e        state;
    trk_kind_e         kind;
    logic [LEN_W-1:0]  prev_len;
    logic [SECT_W-1:0] d_sector;
    logic [CNT_W-1:0]  d_count;
    logic [BLK_W-1:0]  p_block;
    logic [IDX_W-1:0]  p_index;
    logic [PKT_W-1:0]  p_remain;

    logic [SECT_W-1:0] d_sector_nx;
    logic [CNT_W-1:0]  d_count_nx;
    logic              d_done_nx;
    logic [BLK_W-1:0]  p_block_nx;
    logic [IDX_W-1:0]  p_index_nx;
    logic [PKT_W-1:0]  p_remain_nx;
    logic              p_done_nx;
    logic [SECT_W-1:0] p_sector_nx;

    logic              ev;
    logic              ev_ok;
    logic              ev_bad;
    logic              finished;
    logic [SECT_W-1:0] launch_sector;
    trk_resp_t         resp;

    ide_trk_disk_step #(.LEN_W(LEN_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) u_disk (
        .sector    (d_sector),
        .count     (d_count),
        .prev_len  (prev_len),
        .sector_nx (d_sector_nx),
        .count_nx  (d_count_nx),
        .done_nx   (d_done_nx)
    );

    ide_trk_pkt_step #(.LEN_W(LEN_W), .SECT_W(SECT_W), .PKT_W(PKT_W)) u_pkt (
        .block     (p_block),
        .index     (p_index),
        .remain    (p_remain),
        .prev_len  (prev_len),
        .block_nx  (p_block_nx),
        .index_nx  (p_index_nx),
        .remain_nx (p_remain_nx),
        .done_nx   (p_done_nx),
        .sector_nx (p_sector_nx)
    );

    always_comb begin
        ev            = (state == ST_WAIT) && chunk_valid_i;
        ev_bad        = ev && chunk_err_i;
        ev_ok         = ev && !chunk_err_i;
        finished      = (kind == KIND_PKT) ? p_done_nx : d_done_nx;
        launch_sector = (kind == KIND_PKT) ? p_sector_nx : d_sector_nx;
    end

    ide_trk_resp u_resp (
        .event_ok  (ev_ok),
        .event_bad (ev_bad),
        .finished  (finished),
        .resp      (resp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            kind          <= KIND_DISK;
            prev_len      <= '0;
            d_sector      <= '0;
            d_count       <= '0;
            p_block       <= '0;
            p_index       <= '0;
            p_remain      <= '0;
            next_valid_o  <= 1'b0;
            next_sector_o <= '0;
            cmd_done_o    <= 1'b0;
            status_o      <= STAT_BUSY;
            irq_o         <= 1'b0;
            err_o         <= 1'b0;
            dma_end_o     <= 1'b0;
        end else begin
            next_valid_o <= 1'b0;
            cmd_done_o   <= resp.cmd_done;
            irq_o        <= resp.irq;
            err_o        <= resp.err;
            dma_end_o    <= 1'b0;
            if (resp.upd) begin
                status_o <= resp.status;
            end
            unique case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        state    <= ST_WAIT;
                        kind     <= trk_kind_e'(kind_i);
                        prev_len <= '0;
                        d_sector <= start_sector_i;
                        d_count  <= sector_count_i;
                        p_block  <= start_block_i;
                        p_index  <= start_index_i;
                        p_remain <= packet_bytes_i;
                        status_o <= STAT_BUSY;
                    end
                end
                ST_WAIT: begin
                    if (ev_bad) begin
                        state     <= ST_IDLE;
                        dma_end_o <= 1'b1;
                    end else if (ev_ok) begin
                        if (kind == KIND_PKT) begin
                            p_block  <= p_block_nx;
                            p_index  <= p_index_nx;
                            p_remain <= p_remain_nx;
                        end else begin
                            d_sector <= d_sector_nx;
                            d_count  <= d_count_nx;
                        end
                        if (chunk_len_i == '0) begin
                            state     <= ST_IDLE;
                            dma_end_o <= 1'b1;
                        end else begin
                            prev_len      <= chunk_len_i;
                            next_sector_o <= launch_sector;
                            next_valid_o  <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state == ST_WAIT);

endmodule

// File: rtl/ide_dma_tracker_chk.sv
`timescale 1ns/1ps
module ide_dma_tracker_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       chunk_valid_i,
    input logic       busy_o,
    input logic       next_valid_o,
    input logic       cmd_done_o,
    input logic [7:0] status_o,
    input logic       irq_o,
    input logic       err_o,
    input logic       dma_end_o
);
    p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> (busy_o && status_o == 8'h00));

    p_done_irq_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_done_o |-> (irq_o && status_o == 8'h50));

    // R4: status only moves on an event or a start
    p_status_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !chunk_valid_i) |=> $stable(status_o));

    p_end_idle_r8: assert property (@(posedge clk) disable iff (rst)
        dma_end_o |-> !busy_o);

    p_err_end_r9: assert property (@(posedge clk) disable iff (rst)
        err_o |-> (dma_end_o && irq_o && status_o == 8'h51));

    p_err_excl_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_done_o, err_o}));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> (!busy_o && !next_valid_o && !dma_end_o
                                   && !irq_o && !cmd_done_o));

    p_launch_busy_r11: assert property (@(posedge clk) disable iff (rst)
        next_valid_o |-> (busy_o && !dma_end_o));
endmodule

bind ide_dma_tracker ide_dma_tracker_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .chunk_valid_i (chunk_valid_i),
    .busy_o        (busy_o),
    .next_valid_o  (next_valid_o),
    .cmd_done_o    (cmd_done_o),
    .status_o      (status_o),
    .irq_o         (irq_o),
    .err_o         (err_o),
    .dma_end_o     (dma_end_o)
);

// File: tb/ide_dma_tracker_tb.sv
`timescale 1ns/1ps
module ide_dma_tracker_tb;
    localparam int LEN_W  = 16;
    localparam int SECT_W = 32;
    localparam int CNT_W  = 16;
    localparam int PKT_W  = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              kind_i = 1'b0;
    logic [SECT_W-1:0] start_sector_i = '0;
    logic [CNT_W-1:0]  sector_count_i = '0;
    logic [SECT_W-3:0] start_block_i = '0;
    logic [10:0]       start_index_i = '0;
    logic [PKT_W-1:0]  packet_bytes_i = '0;
    logic              chunk_valid_i = 1'b0;
    logic [LEN_W-1:0]  chunk_len_i = '0;
    logic              chunk_err_i = 1'b0;
    logic              busy_o, next_valid_o, cmd_done_o, irq_o, err_o, dma_end_o;
    logic [SECT_W-1:0] next_sector_o;
    logic [7:0]        status_o;

    ide_dma_tracker #(.LEN_W(LEN_W), .SECT_W(SECT_W), .CNT_W(CNT_W), .PKT_W(PKT_W)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .kind_i(kind_i),
        .start_sector_i(start_sector_i), .sector_count_i(sector_count_i),
        .start_block_i(start_block_i), .start_index_i(start_index_i),
        .packet_bytes_i(packet_bytes_i), .chunk_valid_i(chunk_valid_i),
        .chunk_len_i(chunk_len_i), .chunk_err_i(chunk_err_i),
        .busy_o(busy_o), .next_valid_o(next_valid_o), .next_sector_o(next_sector_o),
        .cmd_done_o(cmd_done_o), .status_o(status_o), .irq_o(irq_o),
        .err_o(err_o), .dma_end_o(dma_end_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit finished_run = 0;

    // bench model
    bit               m_pkt;
    logic [31:0]      m_sec;
    logic [15:0]      m_cnt;
    logic [29:0]      m_blk;
    int unsigned      m_idx;
    longint           m_rem;
    int unsigned      m_prev;
    logic [7:0]       m_stat;

    function automatic int unsigned f_ceil_sect(input int unsigned len);
        return (len + 511) >> 9;
    endfunction

    function automatic logic [31:0] f_pkt_sector(input logic [29:0] blk, input int unsigned idx);
        return {blk, 2'b00} + 32'(idx >> 9);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic start(input bit pkt, input logic [31:0] sec, input logic [15:0] cnt,
                         input logic [29:0] blk, input int unsigned idx, input longint rem);
        @(negedge clk);
        start_i = 1'b1; kind_i = pkt; start_sector_i = sec; sector_count_i = cnt;
        start_block_i = blk; start_index_i = 11'(idx); packet_bytes_i = 32'(rem);
        @(negedge clk);
        start_i = 1'b0;
        m_pkt = pkt; m_sec = sec; m_cnt = cnt; m_blk = blk; m_idx = idx;
        m_rem = rem; m_prev = 0; m_stat = 8'h00;
        check(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        check(status_o == 8'h00, "R2", "status after start", status_o, 0);
    endtask

    task automatic ev(input int unsigned len, input bit er);
        bit done_e;
        bit launch;
        logic [31:0] nsec;
        done_e = 0; launch = 0; nsec = '0;
        if (er) begin
            m_stat = 8'h51;
        end else begin
            if (m_pkt) begin
                int unsigned sum;
                sum   = m_idx + m_prev;            // R5
                m_blk = m_blk + 30'(sum >> 11);
                m_idx = sum & 2047;
                m_rem = m_rem - m_prev;            // R7
                done_e = (m_rem <= 0);
                nsec  = f_pkt_sector(m_blk, m_idx); // R6
            end else begin
                m_sec = m_sec + 32'(f_ceil_sect(m_prev));  // R3
                m_cnt = m_cnt - 16'(f_ceil_sect(m_prev));
                done_e = (m_cnt == 16'd0);
                nsec  = m_sec;
            end
            if (done_e) m_stat = 8'h50;
            launch = (len != 0);
            if (launch) m_prev = len;
        end
        @(negedge clk);
        chunk_valid_i = 1'b1; chunk_len_i = 16'(len); chunk_err_i = er;
        @(negedge clk);
        chunk_valid_i = 1'b0; chunk_len_i = '0; chunk_err_i = 1'b0;
        check(err_o == er, "R9", "err pulse", err_o, er);
        check(cmd_done_o == done_e, m_pkt ? "R7" : "R4", "cmd_done", cmd_done_o, done_e);
        check(irq_o == (done_e || er), "R4", "irq", irq_o, done_e || er);
        check(status_o == m_stat, "R4", "status", status_o, m_stat);
        check(dma_end_o == (er || !launch), "R8", "dma_end", dma_end_o, er || !launch);
        check(busy_o == (!er && launch), "R8", "busy", busy_o, !er && launch);
        check(next_valid_o == launch, "R11", "next_valid", next_valid_o, launch);
        if (launch)
            check(next_sector_o == nsec, m_pkt ? "R6" : "R3", "next_sector", next_sector_o, nsec);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished_run) begin
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            summary();
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd1377));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(busy_o == 0, "R1", "busy", busy_o, 0);
        check(status_o == 8'h00, "R1", "status", status_o, 0);
        check({next_valid_o, cmd_done_o, irq_o, err_o, dma_end_o} == 5'b0, "R1", "pulses",
              {next_valid_o, cmd_done_o, irq_o, err_o, dma_end_o}, 0);

        // R10: chunk event while idle is ignored
        chunk_valid_i = 1'b1; chunk_len_i = 16'd512;
        @(negedge clk);
        chunk_valid_i = 1'b0; chunk_len_i = '0;
        check({busy_o, next_valid_o, dma_end_o, irq_o} == 4'b0, "R10", "idle event",
              {busy_o, next_valid_o, dma_end_o, irq_o}, 0);

        // disk directed: R2 first event does not advance, R3 round-up, R4 done
        start(1'b0, 32'd100, 16'd3, '0, 0, 0);
        ev(700, 0);                         // next = 100
        held = next_sector_o;
        // R10: start while busy ignored
        start_i = 1'b1; kind_i = 1'b1; start_sector_i = 32'd9999; sector_count_i = 16'd1;
        @(negedge clk);
        start_i = 1'b0;
        check(next_sector_o == held && busy_o && !next_valid_o, "R10", "start while busy",
              next_sector_o, held);
        ev(512, 0);                         // next = 102, count 1
        ev(0, 0);                           // sector 103, count 0, done

        // packet directed: R5 carry, R6 sector, R7 done at exactly zero
        start(1'b1, '0, '0, 30'd10, 1500, 3000);
        ev(1000, 0);                        // next = 42
        ev(2000, 0);                        // block 11, idx 452, next = 44
        ev(0, 0);                           // remaining 0 -> done

        // packet overshoot: remaining goes negative
        start(1'b1, '0, '0, 30'd7, 2047, 100);
        ev(300, 0);
        ev(0, 0);

        // R9 error aborts
        start(1'b0, 32'd5000, 16'd10, '0, 0, 0);
        ev(512, 0);
        ev(1024, 1);
        check(status_o == 8'h51, "R9", "status held after error", status_o, 8'h51);

        // random mix
        for (int t = 0; t < 40; t++) begin
            bit pkt;
            int nev;
            pkt = $urandom_range(0, 1);
            start(pkt, $urandom, 16'($urandom_range(1, 48)), 30'($urandom_range(0, 100000)),
                  $urandom_range(0, 2047), longint'($urandom_range(1, 30000)));
            nev = $urandom_range(1, 8);
            for (int k = 0; k < nev; k++) begin
                if ($urandom_range(0, 19) == 0) begin
                    ev($urandom_range(1, 8192), 1);
                    break;
                end
                ev((k == nev - 1) ? 0 : $urandom_range(1, 8192), 0);
            end
        end

        finished_run = 1;
        summary();
    end
endmodule